// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This block is a small shared word store that several requesters reach through one arbitrated request port. Each requester presents an opcode, a word address, a write operand and a compare operand. The unit carries out each operation as one indivisible transaction against an internal register-file memory. The supported operations are plain load and store, test-and-set, fetch-and-increment, compare-and-swap, swap, and the load-linked / store-conditional pair.

Because an operation is accepted and finished in a single clock edge, no other requester can observe or modify the word part-way through a read-modify-write. The unit keeps one reservation for each requester so that store-conditional works. A successful write by any other requester clears a reservation on the same word.

The response is registered. It carries the requester ID, the returned data word and a success flag. Software-level locks, counters and lock-free structures can be built on top of these primitives.

Top module: `atomic_mem_unit`

## Requirements
- R1: After reset every memory word reads as zero, no reservation is held, no response is pending, and requester 0 has first priority.
- R2: The opcode field is 3 bits: 0 load, 1 store, 2 test-and-set, 3 fetch-and-increment, 4 compare-and-swap, 5 swap, 6 load-linked, 7 store-conditional. A load returns the word unchanged. A store writes the operand and returns the previous word. Both report success.
- R3: Test-and-set returns the previous word and writes the write operand in the same operation.
- R4: Fetch-and-increment returns the previous word and stores that value plus one, wrapping modulo 2^DW.
- R5: Compare-and-swap returns the previous word. When that word equals the compare operand, it writes the write operand and reports success. Otherwise memory is left unchanged and failure is reported.
- R6: Swap writes the requester's operand into the word and returns the word it replaced.
- R7: Load-linked returns the word and records a reservation for that requester on that address. A later store-conditional from the same requester to the same address, with the reservation still held, writes the operand and returns data 1 with success.
- R8: A store-conditional writes nothing and returns data 0 with failure in three cases: no reservation is held, the reservation is for a different address, or another requester has written the reserved word since the load-linked. Every store-conditional consumes the issuer's reservation.
- R9: At most one request is accepted per cycle. `req_ready` is one-hot or zero and is given only to a requester with `req_valid` high. The response appears exactly one cycle after acceptance, tagged with the accepted requester's index, and at no other time.
- R10: Arbitration is round-robin. The grant goes to the first valid requester after the last granted one, in circular index order, so a requester that holds its request waits through at most NREQ-1 other grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NREQ | Request present, one bit per requester |
| req_ready | output | NREQ | Acceptance, one-hot or zero |
| req_op | input | 3*NREQ | Opcode per requester, requester i in bits [3i+2:3i] |
| req_addr | input | AW*NREQ | Word address per requester |
| req_wdata | input | DW*NREQ | Write operand per requester |
| req_cmp | input | DW*NREQ | Compare operand per requester (compare-and-swap) |
| rsp_valid | output | 1 | Response present |
| rsp_id | output | IDW | Index of the requester being answered |
| rsp_data | output | DW | Previous word, or 1/0 for store-conditional |
| rsp_ok | output | 1 | Success flag |

## Verification
Directed sequences drive one requester at a time. Each opcode is tried on a word whose value is known, including a fetch-and-increment on the all-ones word to expose the wrap. Compare-and-swap is issued both with a matching and with a mismatching compare operand. The load-linked / store-conditional pair is tried in four forms: undisturbed, with another requester writing the word in between, with a different address, and as a repeated store-conditional. These separate correct reservation clearing and consumption from a reservation that never clears or never sets.

A cycle with all requesters valid shows the circular grant order. A long random phase then mixes random valid masks and opcodes over four addresses. This keeps contention and reservation collisions frequent, and it separates a correct rotating pointer from a fixed-priority or stalled one.

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit #(
  parameter int NREQ = 4,
  parameter int AW   = 4,
  parameter int DW   = 32,
  localparam int IDW   = (NREQ > 1) ? $clog2(NREQ) : 1,
  localparam int DEPTH = 1 << AW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NREQ-1:0]      req_valid,
  output logic [NREQ-1:0]      req_ready,
  input  logic [3*NREQ-1:0]    req_op,
  input  logic [AW*NREQ-1:0]   req_addr,
  input  logic [DW*NREQ-1:0]   req_wdata,
  input  logic [DW*NREQ-1:0]   req_cmp,
  output logic                 rsp_valid,
  output logic [IDW-1:0]       rsp_id,
  output logic [DW-1:0]        rsp_data,
  output logic                 rsp_ok
);

  localparam logic [2:0] OP_LD   = 3'd0;
  localparam logic [2:0] OP_ST   = 3'd1;
  localparam logic [2:0] OP_TAS  = 3'd2;
  localparam logic [2:0] OP_FAI  = 3'd3;
  localparam logic [2:0] OP_CAS  = 3'd4;
  localparam logic [2:0] OP_SWP  = 3'd5;
  localparam logic [2:0] OP_LL   = 3'd6;
  localparam logic [2:0] OP_SC   = 3'd7;

  logic [IDW-1:0] rr_ptr;
  logic [IDW-1:0] gnt_idx;
  logic           gnt_found;

  always_comb begin
    gnt_found = 1'b0;
    gnt_idx   = '0;
    for (int k = 1; k <= NREQ; k++) begin
      if (!gnt_found && req_valid[(int'(rr_ptr) + k) % NREQ]) begin
        gnt_found = 1'b1;
        gnt_idx   = IDW'((int'(rr_ptr) + k) % NREQ);
      end
    end
  end

  assign req_ready = gnt_found ? (NREQ'(1) << gnt_idx) : '0;

  wire            fire      = gnt_found;
  wire [2:0]      sel_op    = req_op[int'(gnt_idx)*3 +: 3];
  wire [AW-1:0]   sel_addr  = req_addr[int'(gnt_idx)*AW +: AW];
  wire [DW-1:0]   sel_wdata = req_wdata[int'(gnt_idx)*DW +: DW];
  wire [DW-1:0]   sel_cmp   = req_cmp[int'(gnt_idx)*DW +: DW];

  logic [DW-1:0] mem [DEPTH];
  logic [NREQ-1:0] res_vld;
  logic [AW-1:0]   res_addr [NREQ];

  wire [DW-1:0] old_val = mem[sel_addr];
  wire          sc_hit  = res_vld[gnt_idx] && (res_addr[gnt_idx] == sel_addr);

  logic          wr_en;
  logic [DW-1:0] wr_val;
  logic [DW-1:0] r_data;
  logic          r_ok;

  always_comb begin
    wr_en  = 1'b0;
    wr_val = sel_wdata;
    r_data = old_val;
    r_ok   = 1'b1;
    case (sel_op)
      OP_ST, OP_TAS, OP_SWP: wr_en = 1'b1;
      OP_FAI: begin
        wr_en  = 1'b1;
        wr_val = old_val + DW'(1);
      end
      OP_CAS: begin
        if (old_val == sel_cmp) wr_en = 1'b1;
        else r_ok = 1'b0;
      end
      OP_SC: begin
        if (sc_hit) begin
          wr_en  = 1'b1;
          r_data = DW'(1);
        end else begin
          r_ok   = 1'b0;
          r_data = '0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else if (fire && wr_en) begin
      mem[sel_addr] <= wr_val;
    end
  end

  for (genvar i = 0; i < NREQ; i++) begin : g_res
    wire own = (gnt_idx == IDW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_vld[i]  <= 1'b0;
        res_addr[i] <= '0;
      end else if (fire) begin
        if (own && sel_op == OP_LL) begin
          res_vld[i]  <= 1'b1;
          res_addr[i] <= sel_addr;
        end else if (own && sel_op == OP_SC) begin
          res_vld[i] <= 1'b0;
        end else if (!own && wr_en && res_addr[i] == sel_addr) begin
          res_vld[i] <= 1'b0;
        end
      end
    end

    logic [IDW:0] wait_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wait_cnt <= '0;
      else if (!req_valid[i] || req_ready[i]) wait_cnt <= '0;
      else if (fire) wait_cnt <= wait_cnt + 1'b1;
    end
    AST_RR_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      wait_cnt <= (IDW+1)'(NREQ-1)); // R10
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_ptr <= IDW'(NREQ-1);
    else if (fire) rr_ptr <= gnt_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_id    <= '0;
      rsp_data  <= '0;
      rsp_ok    <= 1'b0;
    end else begin
      rsp_valid <= fire;
      if (fire) begin
        rsp_id   <= gnt_idx;
        rsp_data <= r_data;
        rsp_ok   <= r_ok;
      end
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready)); // R9
  AST_GRANT_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0); // R9
  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req_valid & req_ready)) |=> rsp_valid); // R9
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(req_valid & req_ready)) |=> !rsp_valid); // R9
  AST_FAI_STORES_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sel_op == OP_FAI) |=> mem[$past(sel_addr)] == $past(old_val) + DW'(1)); // R4
  AST_CAS_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sel_op == OP_CAS && old_val != sel_cmp) |=> !rsp_ok && mem[$past(sel_addr)] == $past(old_val)); // R5
  AST_SC_FAIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sel_op == OP_SC && !sc_hit) |=> rsp_data == '0 && mem[$past(sel_addr)] == $past(old_val)); // R8

endmodule

// File: tb/atomic_mem_unit_tb_top.sv
`timescale 1ns/1ps
module atomic_mem_unit_tb_top;
  localparam int NREQ = 4;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int IDW = 2;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NREQ-1:0] req_valid, req_ready;
  logic [3*NREQ-1:0] req_op;
  logic [AW*NREQ-1:0] req_addr;
  logic [DW*NREQ-1:0] req_wdata, req_cmp;
  logic rsp_valid, rsp_ok;
  logic [IDW-1:0] rsp_id;
  logic [DW-1:0] rsp_data;

  logic [2:0]    b_op [NREQ];
  logic [AW-1:0] b_addr [NREQ];
  logic [DW-1:0] b_wd [NREQ];
  logic [DW-1:0] b_cmp [NREQ];

  always_comb begin
    for (int i = 0; i < NREQ; i++) begin
      req_op[i*3 +: 3]      = b_op[i];
      req_addr[i*AW +: AW]  = b_addr[i];
      req_wdata[i*DW +: DW] = b_wd[i];
      req_cmp[i*DW +: DW]   = b_cmp[i];
    end
  end

  atomic_mem_unit #(.NREQ(NREQ), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_cmp(req_cmp),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data), .rsp_ok(rsp_ok));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [DW-1:0] m_mem [DEPTH];
  bit            m_rv [NREQ];
  logic [AW-1:0] m_ra [NREQ];
  int            m_ptr;

  bit            pend;
  int            p_id;
  logic [DW-1:0] p_data;
  bit            p_ok;
  string         p_tag;

  task automatic check(input bit cond, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_exec(input int r, input logic [2:0] op, input logic [AW-1:0] a,
                            input logic [DW-1:0] wd, input logic [DW-1:0] cd,
                            output logic [DW-1:0] d, output bit ok, output string tag);
    logic [DW-1:0] old;
    bit wr;
    logic [DW-1:0] nv;
    old = m_mem[a]; d = old; ok = 1'b1; wr = 1'b0; nv = wd;
    case (op)
      3'd0: tag = "R2";
      3'd1: begin tag = "R2"; wr = 1'b1; end
      3'd2: begin tag = "R3"; wr = 1'b1; end
      3'd3: begin tag = "R4"; wr = 1'b1; nv = old + 1; end
      3'd4: begin tag = "R5"; if (old == cd) wr = 1'b1; else ok = 1'b0; end
      3'd5: begin tag = "R6"; wr = 1'b1; end
      3'd6: begin tag = "R7"; m_rv[r] = 1'b1; m_ra[r] = a; end
      default: begin
        if (m_rv[r] && m_ra[r] == a) begin tag = "R7"; wr = 1'b1; d = 1; end
        else begin tag = "R8"; ok = 1'b0; d = 0; end
        m_rv[r] = 1'b0;
      end
    endcase
    if (wr) begin
      m_mem[a] = nv;
      for (int j = 0; j < NREQ; j++)
        if (j != r && m_ra[j] == a) m_rv[j] = 1'b0;
    end
  endtask

  task automatic step();
    int g;
    logic [NREQ-1:0] exp_rdy;
    @(negedge clk);
    if (pend) begin
      check(rsp_valid == 1'b1, "R9", "rsp_valid", 64'(rsp_valid), 64'(1));
      check(rsp_id == IDW'(p_id), "R9", "rsp_id", 64'(rsp_id), 64'(p_id));
      check(rsp_data == p_data, p_tag, "rsp_data", 64'(rsp_data), 64'(p_data));
      check(rsp_ok == p_ok, p_tag, "rsp_ok", 64'(rsp_ok), 64'(p_ok));
    end else begin
      check(rsp_valid == 1'b0, "R9", "idle rsp_valid", 64'(rsp_valid), 64'(0));
    end
    g = -1;
    for (int k = 1; k <= NREQ; k++) begin
      int c;
      c = (m_ptr + k) % NREQ;
      if (g < 0 && req_valid[c]) g = c;
    end
    exp_rdy = (g < 0) ? '0 : (NREQ'(1) << g);
    check(req_ready == exp_rdy, "R10", "req_ready", 64'(req_ready), 64'(exp_rdy));
    pend = (g >= 0);
    if (g >= 0) begin
      p_id = g;
      m_ptr = g;
      model_exec(g, b_op[g], b_addr[g], b_wd[g], b_cmp[g], p_data, p_ok, p_tag);
    end
    @(posedge clk);
    #1;
  endtask

  task automatic issue(input int r, input logic [2:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd, input logic [DW-1:0] cd);
    req_valid = '0;
    req_valid[r] = 1'b1;
    b_op[r] = op; b_addr[r] = a; b_wd[r] = wd; b_cmp[r] = cd;
    step();
    req_valid = '0;
  endtask

  initial begin
    #(8.0 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL R9 watchdog actual=%0h expected=%0h", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    req_valid = '0;
    for (int i = 0; i < NREQ; i++) begin
      b_op[i] = '0; b_addr[i] = '0; b_wd[i] = '0; b_cmp[i] = '0;
      m_rv[i] = 1'b0; m_ra[i] = '0;
    end
    for (int a = 0; a < DEPTH; a++) m_mem[a] = '0;
    m_ptr = NREQ - 1;
    pend = 1'b0;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R1", "reset rsp_valid", 64'(rsp_valid), 64'(0));
    check(req_ready == '0, "R1", "reset req_ready", 64'(req_ready), 64'(0));
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: every word is zero after reset
    for (int a = 0; a < DEPTH; a++) issue(a % NREQ, 3'd0, AW'(a), '0, '0);
    // R2 store then load
    issue(1, 3'd1, 4'd3, 32'hDEAD_BEEF, '0);
    issue(2, 3'd0, 4'd3, '0, '0);
    // R3 test-and-set twice
    issue(0, 3'd2, 4'd5, 32'd1, '0);
    issue(3, 3'd2, 4'd5, 32'd1, '0);
    // R4 increment and wrap
    issue(2, 3'd3, 4'd5, '0, '0);
    issue(1, 3'd1, 4'd6, 32'hFFFF_FFFF, '0);
    issue(1, 3'd3, 4'd6, '0, '0);
    issue(1, 3'd0, 4'd6, '0, '0);
    // R5 hit and miss
    issue(0, 3'd4, 4'd3, 32'h1234, 32'hDEAD_BEEF);
    issue(3, 3'd4, 4'd3, 32'h5555, 32'hDEAD_BEEF);
    issue(3, 3'd0, 4'd3, '0, '0);
    // R6 swap
    issue(2, 3'd5, 4'd3, 32'hABCD, '0);
    // R7 undisturbed pair, then repeated SC fails (R8)
    issue(1, 3'd6, 4'd7, '0, '0);
    issue(1, 3'd7, 4'd7, 32'h77, '0);
    issue(1, 3'd7, 4'd7, 32'h88, '0);
    // R8 intervening write by another requester
    issue(0, 3'd6, 4'd8, '0, '0);
    issue(2, 3'd1, 4'd8, 32'h9, '0);
    issue(0, 3'd7, 4'd8, 32'h44, '0);
    issue(0, 3'd0, 4'd8, '0, '0);
    // R8 different address
    issue(3, 3'd6, 4'd9, '0, '0);
    issue(3, 3'd7, 4'd10, 32'h66, '0);
    issue(3, 3'd0, 4'd10, '0, '0);
    // R10 all requesters at once, held for several grants
    req_valid = '1;
    for (int i = 0; i < NREQ; i++) begin
      b_op[i] = 3'd3; b_addr[i] = 4'd12; b_wd[i] = '0; b_cmp[i] = '0;
    end
    repeat (2 * NREQ) step();
    req_valid = '0;
    step();

    // random mix with heavy address collisions
    for (int n = 0; n < 4000; n++) begin
      req_valid = NREQ'($urandom_range(0, (1 << NREQ) - 1));
      for (int i = 0; i < NREQ; i++) begin
        b_op[i]   = 3'($urandom_range(0, 7));
        b_addr[i] = AW'($urandom_range(0, 3));
        b_wd[i]   = DW'($urandom_range(0, 7));
        b_cmp[i]  = DW'($urandom_range(0, 7));
      end
      step();
    end
    req_valid = '0;
    step();
    step();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule